// File: doc/BRIEF.md
# Cascaded Prescaler Watchdog Timer

This block is a watchdog that counts pulses of a low-power clock enable through two dividers in series and then through a final timeout counter. The first divider has a coarse ratio that steps by powers of eight. The second has a fine ratio that runs linearly from 1 to 16. When the timeout counter sits at its terminal value, the next clock raises a one-cycle reset request. All counters then restart from zero, and the watchdog keeps running for as long as it stays enabled.

Software keeps the timeout away by pulsing a clear strobe. Three configuration inputs are treated as static and are captured once, on the first clock after reset release: a forced-enable bit and the two divider codes. While the forced-enable bit is set, the watchdog cannot be stopped. While it is clear, a software enable input starts and stops counting.

Top module: `wdt_cascade`

## Requirements
- R1: The coarse code selects the first divider ratio: 2'b00 gives 1, 2'b01 gives 8, 2'b10 gives 64 and 2'b11 gives 512.
- R2: The 4-bit fine code selects a second divider ratio equal to the code plus one, so 4'b0000 gives 1 and 4'b1111 gives 16.
- R3: The dividers act in series. Take N as the coarse ratio times the fine ratio, T as TERM_COUNT (default 16), and tick high on every cycle. The timeout pulse is then seen N*T+1 clocks after the clock edge that samples a clear.
- R4: With the latched forced-enable bit at 1, the watchdog counts and `running` is 1 whatever `sw_enable` is.
- R5: With the latched forced-enable bit at 0, the watchdog counts only while `sw_enable` is 1, and `running` follows it. While it is stopped, all count state is held, and counting resumes from that state.
- R6: `timeout_pulse` is high for exactly one clock. The counters restart from zero on that edge, so the next pulse follows N*T+1 clocks later.
- R7: A clear strobe zeroes both dividers and the timeout counter on the clock it is sampled. A clear in the cycle where the counter sits at its terminal value suppresses that pulse, and a full period restarts.
- R8: The forced-enable bit and both codes are captured on the first clock after reset release. Later changes on those inputs have no effect until the next reset.
- R9: Counting advances only on clocks where `tick` is 1. With both ratios at 1, every tick advances the timeout counter.
- R10: While reset is asserted, `timeout_pulse` and `running` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Clock enable from the free-running low-power clock |
| cfg_force_on | input | 1 | Static enable that software cannot override, captured after reset |
| cfg_coarse | input | 2 | Coarse divider code, captured after reset |
| cfg_fine | input | 4 | Fine divider code, captured after reset |
| sw_enable | input | 1 | Software enable, used when the forced enable is 0 |
| kick | input | 1 | Clear strobe that restarts the whole count |
| timeout_pulse | output | 1 | One-cycle reset request |
| running | output | 1 | High while the watchdog is counting |

## Verification
The timeout period is measured for several code pairs: a single stage active at a time, both stages active together, and the extremes of 1 and 512. These cases separate a wrong ratio decode in either stage from a sum taken in place of a product. The period is measured twice per pair, which shows that the counters restart after a pulse. The following directed cases each isolate one control path:
- stopped ticks
- software enable toggled mid-count, which tells holding from clearing
- a clear landing exactly on the terminal cycle
- codes changed after capture

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int COARSE_CODE_W   = 2;
  localparam int COARSE_LOG_STEP = 3;
  localparam int FINE_CODE_W     = 4;
  localparam int COARSE_LIM_W    = COARSE_LOG_STEP * ((1 << COARSE_CODE_W) - 1);

  typedef struct packed {
    logic                     force_on;
    logic [COARSE_CODE_W-1:0] coarse;
    logic [FINE_CODE_W-1:0]   fine;
  } wdt_cfg_t;

  // Last count value of the coarse stage: ratio 8**code, minus one.
  function automatic logic [COARSE_LIM_W-1:0] coarse_limit(logic [COARSE_CODE_W-1:0] code);
    logic [COARSE_LIM_W:0] v;
    v = '0;
    v[COARSE_LOG_STEP * int'(code)] = 1'b1;
    v = v - {{COARSE_LIM_W{1'b0}}, 1'b1};
    return v[COARSE_LIM_W-1:0];
  endfunction

endpackage

// File: rtl/wdt_cfg_latch.sv
module wdt_cfg_latch
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdt_cfg_t cfg_i,
  output wdt_cfg_t cfg_o,
  output logic     loaded_o
);

  wdt_cfg_t cfg_q, cfg_d;
  logic     loaded_q, loaded_d;

  always_comb begin
    cfg_d    = cfg_q;
    loaded_d = 1'b1;
    if (!loaded_q) cfg_d = cfg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      loaded_q <= loaded_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign loaded_o = loaded_q;

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> $stable(cfg_q));

endmodule

// File: rtl/wdt_div_stage.sv
module wdt_div_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_limit;

  assign at_limit = (cnt_q == limit_i);
  assign done_o   = en_i & at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (en_i)   cnt_d = at_limit ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1 R2
  div_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_i);

endmodule

// File: rtl/wdt_tmo_count.sv
module wdt_tmo_count #(
  parameter int TERM = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic step_i,
  input  logic clr_i,
  output logic wipe_o,
  output logic pulse_o
);

  localparam int TW = $clog2(TERM + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          pulse_q, pulse_d;
  logic          at_term, fire;

  assign at_term = (cnt_q == TW'(TERM));
  assign fire    = active_i & at_term & ~clr_i;
  assign wipe_o  = clr_i | fire;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = fire;
    if (clr_i || fire) cnt_d = '0;
    else if (step_i)   cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0) && !pulse_q);

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !clr_i) |=> $stable(cnt_q));

  // R3
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(TERM));

endmodule

// File: rtl/wdt_cascade.sv
module wdt_cascade
  import wdt_pkg::*;
#(
  parameter int TERM_COUNT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_force_on,
  input  logic [1:0] cfg_coarse,
  input  logic [3:0] cfg_fine,
  input  logic       sw_enable,
  input  logic       kick,
  output logic       timeout_pulse,
  output logic       running
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdt_cfg_t cfg_in, cfg_q;
  logic     loaded;
  logic     active, coarse_done, fine_done, wipe;
  logic [COARSE_LIM_W-1:0] coarse_lim;

  assign cfg_in = '{force_on: cfg_force_on, coarse: cfg_coarse, fine: cfg_fine};

  wdt_cfg_latch i_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_i(cfg_in), .cfg_o(cfg_q), .loaded_o(loaded)
  );

  assign active     = loaded & (cfg_q.force_on | sw_enable);
  assign coarse_lim = coarse_limit(cfg_q.coarse);

  wdt_div_stage #(.W(COARSE_LIM_W)) i_coarse (
    .clk(clk), .rst_n(rst_int_n), .en_i(active & tick), .clr_i(wipe),
    .limit_i(coarse_lim), .done_o(coarse_done)
  );

  wdt_div_stage #(.W(FINE_CODE_W)) i_fine (
    .clk(clk), .rst_n(rst_int_n), .en_i(coarse_done), .clr_i(wipe),
    .limit_i(cfg_q.fine), .done_o(fine_done)
  );

  wdt_tmo_count #(.TERM(TERM_COUNT)) i_tmo (
    .clk(clk), .rst_n(rst_int_n), .active_i(active), .step_i(fine_done),
    .clr_i(kick), .wipe_o(wipe), .pulse_o(timeout_pulse)
  );

  assign running = active;

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    timeout_pulse |=> !timeout_pulse);

endmodule

// File: tb/test_wdt_cascade.sv
module test_wdt_cascade;

  localparam int TERM = 16;
  localparam int NV   = 6;
  localparam logic [1:0] V_COARSE [NV] = '{2'd0, 2'd1, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [3:0] V_FINE   [NV] = '{4'd0, 4'd0, 4'd3, 4'd2, 4'd1, 4'd0};
  localparam logic       V_FORCE  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam int         V_DIV    [NV] = '{1, 8, 4, 24, 128, 512};

  logic clk = 1'b0;
  logic rst_n, tick, cfg_force_on, sw_enable, kick;
  logic [1:0] cfg_coarse;
  logic [3:0] cfg_fine;
  logic timeout_pulse, running;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  wdt_cascade #(.TERM_COUNT(TERM)) i_wdt_cascade (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_force_on(cfg_force_on),
    .cfg_coarse(cfg_coarse), .cfg_fine(cfg_fine), .sw_enable(sw_enable),
    .kick(kick), .timeout_pulse(timeout_pulse), .running(running)
  );

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected under 150000", cyc);
      report();
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic frc, logic [1:0] crs, logic [3:0] fn, logic sw);
    @(negedge clk);
    rst_n = 1'b0; cfg_force_on = frc; cfg_coarse = crs; cfg_fine = fn;
    sw_enable = sw; kick = 1'b0; tick = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 pulse in reset", int'(timeout_pulse), 0);
    check("R10 running in reset", int'(running), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic kick_once;
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // Counts negedges from the current one until the pulse is seen.
  task automatic wait_pulse(int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (timeout_pulse) begin n = i; break; end
    end
  endtask

  task automatic quiet(string req, int cycles);
    int seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (timeout_pulse) seen = 1;
    end
    check(req, seen, 0);
  endtask

  initial begin
    int n, per;
    rst_n = 1'b0; tick = 1'b0; cfg_force_on = 1'b0; cfg_coarse = '0;
    cfg_fine = '0; sw_enable = 1'b0; kick = 1'b0;

    // Table walk: R1 R2 R3 R6, R4 for forced rows, R5 for software-enabled rows
    for (int v = 0; v < NV; v++) begin
      do_reset(V_FORCE[v], V_COARSE[v], V_FINE[v], ~V_FORCE[v]);
      check("R4 R5 running after load", int'(running), 1);
      per = V_DIV[v] * TERM + 1;
      kick_once();
      wait_pulse(per + 20, n);
      check("R1 R2 R3 period after clear", n, per);
      @(negedge clk);
      check("R6 pulse one cycle", int'(timeout_pulse), 0);
      wait_pulse(per + 20, n);
      check("R6 restart period", n + 1, per);
    end

    // R4: forced enable ignores software enable toggling
    do_reset(1'b1, 2'd0, 4'd0, 1'b1);
    kick_once();
    sw_enable = 1'b0;
    wait_pulse(60, n);
    check("R4 forced run with sw off", n, TERM + 1);
    check("R4 running with sw off", int'(running), 1);

    // R5: software enable stops, holds and resumes
    do_reset(1'b0, 2'd0, 4'd0, 1'b0);
    check("R5 running while sw off", int'(running), 0);
    kick_once();
    quiet("R5 no pulse while stopped", 40);
    sw_enable = 1'b1;
    repeat (8) @(negedge clk);
    check("R5 running while sw on", int'(running), 1);
    sw_enable = 1'b0;
    quiet("R5 no pulse while paused", 30);
    sw_enable = 1'b1;
    wait_pulse(60, n);
    check("R5 count held across pause", n, TERM + 1 - 8);

    // R7: clear in the terminal cycle suppresses the pulse
    do_reset(1'b1, 2'd0, 4'd0, 1'b0);
    kick_once();
    repeat (16) @(negedge clk);
    check("R7 no pulse before terminal", int'(timeout_pulse), 0);
    kick_once();
    check("R7 pulse suppressed by clear", int'(timeout_pulse), 0);
    wait_pulse(60, n);
    check("R7 full period after clear", n, TERM + 1);

    // R8: changes after capture are ignored
    do_reset(1'b1, 2'd0, 4'd0, 1'b0);
    cfg_force_on = 1'b0; cfg_coarse = 2'd3; cfg_fine = 4'd15;
    kick_once();
    wait_pulse(60, n);
    check("R8 codes frozen after load", n, TERM + 1);
    check("R8 force bit frozen", int'(running), 1);

    // R9: no progress without ticks
    kick_once();
    tick = 1'b0;
    quiet("R9 no pulse without ticks", 60);
    tick = 1'b1;
    wait_pulse(60, n);
    check("R9 every tick advances at ratio 1", n, TERM + 1);

    report();
  end

endmodule